// File: doc/BRIEF.md
# Conditional Control-Transfer Sequencer

This block is the part of an 8-bit processor core that carries out control transfers in a 16-bit address space. The supported transfers are an absolute jump, a relative jump, a subroutine call, a subroutine return and a jump to the HL register pair. The surrounding core decodes the instruction and fetches the opcode. It then raises a one-cycle start request with the transfer kind, a condition selector and the current Z and C flags. At that moment PC already points at the first operand byte.

The sequencer takes over from there. It drives a byte-wide memory port, one cycle at a time, using three kinds of access: a read at PC, a load from a computed address and a store to a computed address. It owns the PC and SP registers and updates them as the transfer proceeds. The condition is evaluated once, when the request is accepted. A transfer that is not taken still consumes its operand bytes. A taken jump, call or return ends with one idle stall cycle.

A busy output covers the whole sequence. A done output pulses in its final cycle, and the core uses it to resume fetching.

Top module: `xfer_seq`

## Requirements
- R1: The condition selector codes are 0 = always, 1 = C set, 2 = Z set, 3 = C clear and 4 = Z clear; codes 5 to 7 never pass. The flags are sampled only in the cycle the start request is accepted.
- R2: A taken absolute jump (kind 0) runs in three cycles. It reads the low byte at PC, then the high byte at PC+1, then idles for one stall cycle. PC becomes high*256 + low.
- R3: A jump or call whose condition fails still reads its operand bytes: two for an absolute jump or call, one for a relative jump. PC advances past them, no stall cycle follows, no store takes place, and done is raised in the last read cycle.
- R4: A relative jump (kind 1) reads one byte at PC and treats it as a signed two's-complement offset. When taken, the new PC is the address following that byte plus the offset, and one stall cycle follows.
- R5: A taken call (kind 2) runs in five cycles. It stores the low byte of the return address (the first operand address + 2) at SP-2 and the high byte at SP-1, and leaves SP lowered by 2. It then reads the two target bytes low first and ends with a stall. SP does not change during the read cycles.
- R6: A taken return (kind 3) runs in three cycles. It loads the low byte from SP, then the high byte from SP+1, then stalls. At the end PC = high*256 + low and SP has risen by 2.
- R7: A return whose condition fails finishes in one cycle with no memory access, and leaves PC and SP unchanged.
- R8: A jump to HL (kind 4) finishes in one cycle with no memory access and copies the HL input into PC, whatever the condition.
- R9: Every read-at-PC cycle advances PC by one unless that cycle loads a taken target. All PC and SP arithmetic wraps modulo 2^16.
- R10: Busy stays high from the cycle after an accepted request until done, and done is a single-cycle pulse in the final cycle. A start request is ignored while busy, and a request with a kind code of 5 to 7 is never accepted.
- R11: The access type encoding is 0 = none, 1 = read at PC, 2 = load and 3 = store. Write data is zero unless the access is a store. After reset PC = 0x0100, SP = 0xFFFE, busy and done are low, and the access type is none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin a transfer, taken only while idle |
| op_kind | input | 3 | Transfer kind: 0 absolute jump, 1 relative jump, 2 call, 3 return, 4 jump to HL |
| cond_sel | input | 3 | Condition selector (R1 encoding) |
| flag_z | input | 1 | Zero flag from the core |
| flag_c | input | 1 | Carry flag from the core |
| hl_in | input | 16 | Current HL register pair |
| mem_rdata | input | 8 | Byte returned by memory for the current address |
| mem_addr | output | 16 | Memory address for the current access |
| mem_wdata | output | 8 | Byte to store, zero when not storing |
| cyc_type | output | 2 | Access type (R11 encoding) |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | Final cycle of a transfer |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |

## Verification
The hardest case to reach from the ports is an address wrap in the middle of an operand fetch. PC only moves through transfers, so an operand byte at 0xFFFF is reached by first doing a jump to HL with HL = 0xFFFF. A relative jump and a not-taken absolute jump are then issued from that address. The bench also holds start high, with a different kind, throughout a running transfer, to show that a request arriving while busy neither restarts nor disturbs the transfer. Call and return are run back to back, so the return address read back is the one the call stored.

// File: rtl/xfer_pkg.sv
// Shared encodings for the control-transfer sequencer.
// Assumes: the address is exactly two data bytes wide.
package xfer_pkg;

    // Transfer kinds presented by the decoder.
    typedef enum logic [2:0] {
        OPK_JP_ABS = 3'd0,
        OPK_JP_REL = 3'd1,
        OPK_CALL   = 3'd2,
        OPK_RET    = 3'd3,
        OPK_JP_HL  = 3'd4
    } opk_e;

    // Condition selector codes.
    typedef enum logic [2:0] {
        CC_ALWAYS = 3'd0,
        CC_C_SET  = 3'd1,
        CC_Z_SET  = 3'd2,
        CC_C_CLR  = 3'd3,
        CC_Z_CLR  = 3'd4
    } cc_e;

    // Memory access type driven on the port.
    typedef enum logic [1:0] {
        CYC_NONE  = 2'd0,
        CYC_RD_PC = 2'd1,
        CYC_LOAD  = 2'd2,
        CYC_STORE = 2'd3
    } cyc_e;

    // Sequencer states, one memory slot each.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH_LO,
        ST_FETCH_HI,
        ST_FETCH_REL,
        ST_PUSH_LO,
        ST_PUSH_HI,
        ST_POP_LO,
        ST_POP_HI,
        ST_STALL,
        ST_HL
    } st_e;

endpackage

// File: rtl/xfer_cond.sv
// Condition evaluator: maps a selector code and the Z/C flags to pass/fail.
// Assumes: selector codes outside the defined set never pass.
module xfer_cond
    import xfer_pkg::*;
(
    input  logic [2:0] cond_sel,
    input  logic       flag_z,
    input  logic       flag_c,
    output logic       pass
);

    // Decode the selector against the flags.
    always_comb begin
        case (cond_sel)
            CC_ALWAYS: pass = 1'b1;
            CC_C_SET:  pass = flag_c;
            CC_Z_SET:  pass = flag_z;
            CC_C_CLR:  pass = ~flag_c;
            CC_Z_CLR:  pass = ~flag_z;
            default:   pass = 1'b0;
        endcase
    end

endmodule

// File: rtl/xfer_ctrl.sv
// Sequencer control: accepts a request while idle, latches the condition
// result, walks the state sequence of the chosen transfer, and decodes busy
// and done from the state.
// Assumes: start is a request the core may hold; it is only sampled in idle.
module xfer_ctrl
    import xfer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [2:0] op_kind,
    input  logic       pass,
    output st_e        state,
    output logic       taken,
    output logic       busy,
    output logic       done
);

    st_e  nxt;
    logic kind_ok;
    logic accept;

    // A request is valid only for a defined transfer kind.
    always_comb begin
        case (op_kind)
            OPK_JP_ABS, OPK_JP_REL, OPK_CALL, OPK_RET, OPK_JP_HL: kind_ok = 1'b1;
            default: kind_ok = 1'b0;
        endcase
    end

    assign accept = (state == ST_IDLE) && start && kind_ok;

    // Next-state selection for every transfer sequence.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: begin
                if (accept) begin
                    case (op_kind)
                        OPK_JP_ABS: nxt = ST_FETCH_LO;
                        OPK_JP_REL: nxt = ST_FETCH_REL;
                        OPK_CALL:   nxt = pass ? ST_PUSH_LO : ST_FETCH_LO;
                        OPK_RET:    nxt = ST_POP_LO;
                        default:    nxt = ST_HL;
                    endcase
                end
            end
            ST_FETCH_LO:  nxt = ST_FETCH_HI;
            ST_FETCH_HI:  nxt = taken ? ST_STALL : ST_IDLE;
            ST_FETCH_REL: nxt = taken ? ST_STALL : ST_IDLE;
            ST_PUSH_LO:   nxt = ST_PUSH_HI;
            ST_PUSH_HI:   nxt = ST_FETCH_LO;
            ST_POP_LO:    nxt = taken ? ST_POP_HI : ST_IDLE;
            ST_POP_HI:    nxt = ST_STALL;
            ST_STALL:     nxt = ST_IDLE;
            ST_HL:        nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // State register and condition latch, captured once at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            taken <= 1'b0;
        end else begin
            state <= nxt;
            if (accept) taken <= (op_kind == OPK_JP_HL) ? 1'b1 : pass;
        end
    end

    assign busy = (state != ST_IDLE);

    // Final-cycle decode for each sequence.
    always_comb begin
        case (state)
            ST_FETCH_HI, ST_FETCH_REL, ST_POP_LO: done = ~taken;
            ST_STALL, ST_HL:                      done = 1'b1;
            default:                              done = 1'b0;
        endcase
    end

endmodule

// File: rtl/xfer_path.sv
// Sequencer datapath: holds PC, SP and the low-byte latch, and forms the
// memory address, write data and access type for the current state.
// Assumes: ADDR_W equals 2*DATA_W; memory returns read data in the same cycle.
module xfer_path
    import xfer_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter int          DATA_W = 8,
    parameter logic [15:0] PC_RST = 16'h0100,
    parameter logic [15:0] SP_RST = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  st_e               state,
    input  logic              taken,
    input  logic [ADDR_W-1:0] hl_in,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [1:0]        cyc_type,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] sp
);

    localparam int EXT_W = ADDR_W - DATA_W;

    logic [DATA_W-1:0] lo_q;
    logic [ADDR_W-1:0] pc_inc;
    logic [ADDR_W-1:0] ret_addr;
    logic [ADDR_W-1:0] rel_off;
    logic [ADDR_W-1:0] joined;

    assign pc_inc   = pc + ADDR_W'(1);
    assign ret_addr = pc + ADDR_W'(2);
    assign rel_off  = {{EXT_W{mem_rdata[DATA_W-1]}}, mem_rdata};
    assign joined   = {mem_rdata, lo_q};

    // Memory port drive for the current state.
    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        cyc_type  = CYC_NONE;
        case (state)
            ST_FETCH_LO, ST_FETCH_HI, ST_FETCH_REL: begin
                cyc_type = CYC_RD_PC;
                mem_addr = pc;
            end
            ST_PUSH_LO: begin
                cyc_type  = CYC_STORE;
                mem_addr  = sp - ADDR_W'(2);
                mem_wdata = ret_addr[DATA_W-1:0];
            end
            ST_PUSH_HI: begin
                cyc_type  = CYC_STORE;
                mem_addr  = sp + ADDR_W'(1);
                mem_wdata = ret_addr[ADDR_W-1:DATA_W];
            end
            ST_POP_LO: begin
                if (taken) begin
                    cyc_type = CYC_LOAD;
                    mem_addr = sp;
                end
            end
            ST_POP_HI: begin
                cyc_type = CYC_LOAD;
                mem_addr = sp + ADDR_W'(1);
            end
            default: ;
        endcase
    end

    // PC, SP and low-byte latch updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc   <= ADDR_W'(PC_RST);
            sp   <= ADDR_W'(SP_RST);
            lo_q <= '0;
        end else begin
            case (state)
                ST_FETCH_LO: begin
                    pc   <= pc_inc;
                    lo_q <= mem_rdata;
                end
                ST_FETCH_HI:  pc <= taken ? joined : pc_inc;
                ST_FETCH_REL: pc <= taken ? (pc_inc + rel_off) : pc_inc;
                ST_PUSH_LO:   sp <= sp - ADDR_W'(2);
                ST_POP_LO:    if (taken) lo_q <= mem_rdata;
                ST_POP_HI: begin
                    pc <= joined;
                    sp <= sp + ADDR_W'(2);
                end
                ST_HL:        pc <= hl_in;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/xfer_seq.sv
// Top of the control-transfer sequencer: condition evaluator, control state
// machine and datapath.
// Assumes: the core raises start only with PC pointing at the first operand
// byte, and samples done to resume instruction fetch.
module xfer_seq
    import xfer_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter int          DATA_W = 8,
    parameter logic [15:0] PC_RST = 16'h0100,
    parameter logic [15:0] SP_RST = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op_kind,
    input  logic [2:0]        cond_sel,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic [ADDR_W-1:0] hl_in,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [1:0]        cyc_type,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] sp
);

    logic pass;
    logic taken;
    st_e  state;

    xfer_cond u_cond (
        .cond_sel (cond_sel),
        .flag_z   (flag_z),
        .flag_c   (flag_c),
        .pass     (pass)
    );

    xfer_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op_kind (op_kind),
        .pass    (pass),
        .state   (state),
        .taken   (taken),
        .busy    (busy),
        .done    (done)
    );

    xfer_path #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PC_RST (PC_RST),
        .SP_RST (SP_RST)
    ) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .taken     (taken),
        .hl_in     (hl_in),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .cyc_type  (cyc_type),
        .pc        (pc),
        .sp        (sp)
    );

endmodule

// File: rtl/xfer_seq_chk.sv
// Port-level protocol checker for the sequencer, bound to the top.
module xfer_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [1:0]        cyc_type,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [ADDR_W-1:0] pc,
    input logic [ADDR_W-1:0] sp
);

    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R10

    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R10

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R10

    AST_WDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type != 2'd3) |-> (mem_wdata == '0)); // R11

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type == 2'd1 && !done) |=>
            ((cyc_type == 2'd1 && pc == $past(pc) + ADDR_W'(1)) || cyc_type == 2'd0)); // R9

    AST_SP_STILL_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type == 2'd1) |=> (sp == $past(sp))); // R5

    AST_STORE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cyc_type == 2'd3) |=>
            (cyc_type == 2'd3 && mem_addr == $past(mem_addr) + ADDR_W'(1))); // R5

    AST_LOAD_AT_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type == 2'd2) |-> (mem_addr == sp || mem_addr == sp + ADDR_W'(1))); // R6

endmodule

bind xfer_seq xfer_seq_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .cyc_type  (cyc_type),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .pc        (pc),
    .sp        (sp)
);

// File: tb/xfer_seq_bench.sv
// Directed bench for the control-transfer sequencer.
module xfer_seq_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_kind = 3'd0;
    logic [2:0]  cond_sel = 3'd0;
    logic        flag_z = 1'b0;
    logic        flag_c = 1'b0;
    logic [15:0] hl_in = 16'h0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [1:0]  cyc_type;
    logic        busy;
    logic        done;
    logic [15:0] pc;
    logic [15:0] sp;

    logic [7:0]  mem [0:255];
    logic [1:0]  tr_cyc  [0:7];
    logic [15:0] tr_addr [0:7];
    logic [7:0]  tr_wd   [0:7];
    int          ncyc;
    int          n_chk = 0;
    int          n_bad = 0;

    assign mem_rdata = mem[mem_addr[7:0]];

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_seq u_xfer_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op_kind   (op_kind),
        .cond_sel  (cond_sel),
        .flag_z    (flag_z),
        .flag_c    (flag_c),
        .hl_in     (hl_in),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .cyc_type  (cyc_type),
        .busy      (busy),
        .done      (done),
        .pc        (pc),
        .sp        (sp)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Issue one transfer and trace it until done; the bench acts as memory.
    task automatic issue(input logic [2:0] op, input logic [2:0] cc,
                         input logic z, input logic c, input logic hold);
        @(negedge clk);
        start = 1'b1; op_kind = op; cond_sel = cc; flag_z = z; flag_c = c;
        @(negedge clk);
        if (hold) op_kind = 3'd4; else start = 1'b0;
        hl_in = hold ? 16'hDEAD : hl_in;
        ncyc = 0;
        forever begin
            if (ncyc < 8) begin
                tr_cyc[ncyc]  = cyc_type;
                tr_addr[ncyc] = mem_addr;
                tr_wd[ncyc]   = mem_wdata;
            end
            if (cyc_type == 2'd3) mem[mem_addr[7:0]] = mem_wdata;
            ncyc++;
            if (done || ncyc > 20) break;
            @(negedge clk);
        end
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic set_pc(input logic [15:0] v);
        hl_in = v;
        issue(3'd4, 3'd0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset;
        chk("R11 reset pc", pc, 16'h0100);
        chk("R11 reset sp", sp, 16'hFFFE);
        chk("R11 reset busy", busy, 0);
        chk("R11 reset done", done, 0);
        chk("R11 reset cyc", cyc_type, 0);
    endtask

    task automatic t_jp_hl;
        set_pc(16'h0120);
        chk("R8 cycles", ncyc, 1);
        chk("R8 no access", tr_cyc[0], 0);
        chk("R8 pc", pc, 16'h0120);
    endtask

    task automatic t_jp_abs;
        mem[8'h20] = 8'h50; mem[8'h21] = 8'h02;
        issue(3'd0, 3'd0, 1'b0, 1'b0, 1'b0);
        chk("R2 cycles", ncyc, 3);
        chk("R2 rd lo type", tr_cyc[0], 1);
        chk("R2 rd lo addr", tr_addr[0], 16'h0120);
        chk("R2 rd hi addr", tr_addr[1], 16'h0121);
        chk("R2 stall type", tr_cyc[2], 0);
        chk("R2 pc", pc, 16'h0250);
        issue(3'd0, 3'd2, 1'b0, 1'b1, 1'b0);
        chk("R3 jp not taken cycles", ncyc, 2);
        chk("R3 jp not taken pc", pc, 16'h0252);
    endtask

    task automatic t_jr;
        mem[8'h52] = 8'hF0;
        issue(3'd1, 3'd4, 1'b0, 1'b1, 1'b0);
        chk("R4 jr back cycles", ncyc, 2);
        chk("R4 jr back pc", pc, 16'h0243);
        mem[8'h43] = 8'h10;
        issue(3'd1, 3'd1, 1'b1, 1'b0, 1'b0);
        chk("R1 C set fails cycles", ncyc, 1);
        chk("R3 jr not taken pc", pc, 16'h0244);
        mem[8'h44] = 8'h7F;
        issue(3'd1, 3'd3, 1'b1, 1'b0, 1'b0);
        chk("R1 C clear passes pc", pc, 16'h02C4);
        issue(3'd1, 3'd5, 1'b1, 1'b1, 1'b0);
        chk("R1 code 5 never passes pc", pc, 16'h02C5);
        set_pc(16'h02C4);
    endtask

    task automatic t_call_ret;
        mem[8'hC4] = 8'h88; mem[8'hC5] = 8'h03;
        issue(3'd2, 3'd1, 1'b0, 1'b1, 1'b0);
        chk("R5 cycles", ncyc, 5);
        chk("R5 store lo addr", tr_addr[0], 16'hFFFC);
        chk("R5 store lo data", tr_wd[0], 8'hC6);
        chk("R5 store hi addr", tr_addr[1], 16'hFFFD);
        chk("R5 store hi data", tr_wd[1], 8'h02);
        chk("R5 store type", tr_cyc[1], 3);
        chk("R5 fetch addr", tr_addr[2], 16'h02C4);
        chk("R5 stall", tr_cyc[4], 0);
        chk("R5 pc", pc, 16'h0388);
        chk("R5 sp", sp, 16'hFFFC);
        issue(3'd2, 3'd2, 1'b0, 1'b0, 1'b0);
        chk("R3 call not taken cycles", ncyc, 2);
        chk("R3 call not taken store", (tr_cyc[0] == 3) || (tr_cyc[1] == 3), 0);
        chk("R3 call not taken pc", pc, 16'h038A);
        chk("R3 call not taken sp", sp, 16'hFFFC);
        issue(3'd3, 3'd4, 1'b1, 1'b0, 1'b0);
        chk("R7 cycles", ncyc, 1);
        chk("R7 no access", tr_cyc[0], 0);
        chk("R7 pc", pc, 16'h038A);
        chk("R7 sp", sp, 16'hFFFC);
        issue(3'd3, 3'd0, 1'b0, 1'b0, 1'b0);
        chk("R6 cycles", ncyc, 3);
        chk("R6 load lo", tr_addr[0], 16'hFFFC);
        chk("R6 load hi", tr_addr[1], 16'hFFFD);
        chk("R6 load type", tr_cyc[1], 2);
        chk("R6 pc", pc, 16'h02C6);
        chk("R6 sp", sp, 16'hFFFE);
    endtask

    task automatic t_busy_ignore;
        mem[8'hC6] = 8'h00; mem[8'hC7] = 8'h05;
        issue(3'd0, 3'd0, 1'b0, 1'b0, 1'b1);
        chk("R10 held start cycles", ncyc, 3);
        chk("R10 held start pc", pc, 16'h0500);
        chk("R10 idle after", busy, 0);
        @(negedge clk);
        start = 1'b1; op_kind = 3'd6;
        @(negedge clk);
        start = 1'b0;
        chk("R10 bad kind not accepted", busy, 0);
        chk("R10 bad kind pc", pc, 16'h0500);
    endtask

    task automatic t_wrap;
        set_pc(16'hFFFF);
        mem[8'hFF] = 8'h05;
        issue(3'd1, 3'd0, 1'b0, 1'b0, 1'b0);
        chk("R9 jr read addr", tr_addr[0], 16'hFFFF);
        chk("R9 jr wrap pc", pc, 16'h0005);
        set_pc(16'hFFFF);
        issue(3'd0, 3'd1, 1'b0, 1'b0, 1'b0);
        chk("R9 second read wraps", tr_addr[1], 16'h0000);
        chk("R9 pc wraps", pc, 16'h0001);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_jp_hl();
        t_jp_abs();
        t_jr();
        t_call_ret();
        t_busy_ignore();
        t_wrap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule